// File: doc/BRIEF.md
# Broadcast-Loaded Multichannel PWM Generator

This block drives a row of PWM outputs from one shared up-counting timebase. The counter runs from zero to a programmable top value and then restarts at zero, so every channel has a period of top plus one clock cycles. Each channel compares the running count with its own duty value. A channel whose duty is zero stays low. Any other channel is high while the count is at or below its duty value.

Software reaches the block through a small write-only register port. Duty values are never written one channel at a time. A single shared duty value is written first. A channel-select mask then copies that value into every channel whose mask bit is set, all in one operation. A ready flag marks when the block can accept a mask. Newly loaded duty values and a new top value wait for the next wrap of the timebase. A control bit restarts the timebase at once, and that restart also loads the pending values. Even-numbered outputs switch on the rising clock edge and odd-numbered outputs switch on the falling edge, so that fewer pins change state at the same moment.

Top module: `pwm_bcast`

## Requirements
- R1: The timebase counts 0, 1, ..., top and then returns to 0. One PWM period is therefore top+1 clock cycles.
- R2: A channel whose active duty value is 0 drives its output low for the whole period.
- R3: A channel with a nonzero duty value d is high in the cycles where the count is at most d. Per period this gives 2 high cycles for d=1, d+1 high cycles for 1<d<top, and top+1 high cycles (always high) for d>=top.
- R4: Even-indexed outputs update on the rising clock edge and odd-indexed outputs on the falling edge. Half a cycle after a rising edge, the odd outputs already show the comparison for the current count, while the even outputs still show the comparison for the previous count.
- R5: The register port decodes wr_addr as follows: 0 is control (wr_data bit 0 = timebase clear), 1 is the top value, 2 is the shared duty value, and 3 is the channel-select mask (wr_data bit m selects channel m). All registers are write-only.
- R6: A mask write accepted while ready is 1 copies the shared duty value into the pending duty of every channel whose mask bit is 1. Channels whose mask bit is 0 keep their previous duty.
- R7: After an accepted mask write, ready is 0 for exactly one cycle. A mask write presented while ready is 0 is ignored.
- R8: A pending duty value becomes active only at the next timebase wrap or clear. The period already in progress is unaffected.
- R9: A written top value becomes effective only at the next timebase wrap or clear.
- R10: Writing 1 to the clear bit sets the count to 0 on the next cycle. The same clear loads the written top value and all pending duty values.
- R11: After reset all outputs are low, ready is 1, every duty value is 0, and the top value is the TOP_RST parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Even outputs use its rising edge and odd outputs use its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 top, 2 shared duty, 3 channel mask |
| wr_data | input | DW | Write data |
| ready | output | 1 | High when a channel-mask write will be accepted |
| pwm_o | output | NCH | PWM outputs, one per channel |

## Verification
The duty-to-high-time mapping is swept over several top values. Within each sweep, all four channels carry consecutive duty values from 0 up to two past the top value. This separates the zero case, the jump to two high cycles at duty one, the linear middle range, and the saturation at and beyond the top value. Three further timed sequences load a new duty value in the middle of a period, load a new top value in the middle of a period, and issue a mask write on the cycle right after another mask write. These sequences distinguish deferred loading from immediate loading, and they show whether a write made while the block is busy is dropped. The outputs are also sampled half a cycle after a rising edge, which tells rising-edge channels apart from falling-edge channels.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_TOP    = 2'd1,
      SEL_SHARED = 2'd2,
      SEL_MASK   = 2'd3
   } reg_sel_e;

   localparam int CTRL_CLEAR_BIT = 0;

endpackage

// File: rtl/pwmb_timebase.sv
module pwmb_timebase #(
   parameter int CW      = 4,
   parameter int TOP_RST = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          top_we,
   input  logic [CW-1:0] top_val,
   input  logic          clr,
   output logic [CW-1:0] cnt,
   output logic          reload
);

   logic [CW-1:0] top_reg;
   logic [CW-1:0] eff_top;
   logic [CW-1:0] cnt_q;
   logic          at_top;

   assign at_top = (cnt_q == eff_top);
   assign reload = clr | at_top;
   assign cnt    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_reg <= CW'(TOP_RST);
         eff_top <= CW'(TOP_RST);
         cnt_q   <= '0;
      end else begin
         if (top_we) top_reg <= top_val;
         if (reload) begin
            cnt_q   <= '0;
            eff_top <= top_reg;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= eff_top); // R1
   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) at_top |=> (cnt_q == '0)); // R1
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n) (!clr && !at_top) |=> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R1
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (cnt_q == '0)); // R10
   AST_TOP_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n) !reload |=> $stable(eff_top)); // R9

endmodule

// File: rtl/pwmb_bcast.sv
module pwmb_bcast #(
   parameter int NCH = 4,
   parameter int CW  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shared_we,
   input  logic [CW-1:0]  shared_val,
   input  logic           mask_we,
   input  logic [NCH-1:0] mask,
   output logic           ready,
   output logic [NCH-1:0] stage_we,
   output logic [CW-1:0]  stage_val
);

   logic          busy;
   logic          accept;
   logic [CW-1:0] shared_q;

   assign accept    = mask_we & ~busy;
   assign ready     = ~busy;
   assign stage_we  = accept ? mask : '0;
   assign stage_val = shared_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         shared_q <= '0;
      end else begin
         busy <= accept;
         if (shared_we) shared_q <= shared_val;
      end
   end

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (mask_we && ready) |=> !ready); // R7
   AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n) !ready |=> ready); // R7

endmodule

// File: rtl/pwmb_channel.sv
module pwmb_channel #(
   parameter int CW        = 4,
   parameter bit FALL_EDGE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stage_we,
   input  logic [CW-1:0] stage_val,
   input  logic          reload,
   input  logic [CW-1:0] cnt,
   output logic          pwm
);

   logic [CW-1:0] duty_stg;
   logic [CW-1:0] duty_act;
   logic          raw;
   logic          pwm_q;

   assign raw = (duty_act != '0) && (cnt <= duty_act);
   assign pwm = pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_stg <= '0;
         duty_act <= '0;
      end else begin
         if (stage_we) duty_stg <= stage_val;
         if (reload)   duty_act <= duty_stg;
      end
   end

   generate
      if (FALL_EDGE) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= raw;
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pwm_q <= 1'b0;
            else        pwm_q <= raw;
         end

         AST_ZERO_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (duty_act == '0) |=> !pwm_q); // R2
         AST_PERIOD_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ((duty_act != '0) && (cnt == '0)) |=> pwm_q); // R3
      end
   endgenerate

   AST_DUTY_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n) !reload |=> $stable(duty_act)); // R8
   AST_STAGE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n) !stage_we |=> $stable(duty_stg)); // R6

endmodule

// File: rtl/pwm_bcast.sv
module pwm_bcast
   import pwmb_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int CW      = 4,
   parameter int DW      = 32,
   parameter int TOP_RST = (1 << CW) - 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [1:0]     wr_addr,
   input  logic [DW-1:0]  wr_data,
   output logic           ready,
   output logic [NCH-1:0] pwm_o
);

   localparam int TOP_MAX = (1 << CW) - 1;

   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("pwm_bcast: NCH must lie in 1..32");
      end
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("pwm_bcast: CW must lie in 2..16");
      end
      if (DW < CW || DW < NCH) begin : g_bad_dw
         $error("pwm_bcast: DW must cover both CW and NCH");
      end
      if (TOP_RST < 1 || TOP_RST > TOP_MAX) begin : g_bad_top
         $error("pwm_bcast: TOP_RST must lie in 1..2**CW-1");
      end
   endgenerate

   reg_sel_e       sel;
   logic           clr;
   logic           top_we;
   logic           shared_we;
   logic           mask_we;
   logic [CW-1:0]  cnt;
   logic           reload;
   logic [NCH-1:0] stage_we;
   logic [CW-1:0]  stage_val;
   logic           unused_wdata;

   assign sel          = reg_sel_e'(wr_addr);
   assign clr          = wr_en && (sel == SEL_CTRL) && wr_data[CTRL_CLEAR_BIT];
   assign top_we       = wr_en && (sel == SEL_TOP);
   assign shared_we    = wr_en && (sel == SEL_SHARED);
   assign mask_we      = wr_en && (sel == SEL_MASK);
   assign unused_wdata = ^wr_data;

   pwmb_timebase #(
      .CW      (CW),
      .TOP_RST (TOP_RST)
   ) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .top_we  (top_we),
      .top_val (wr_data[CW-1:0]),
      .clr     (clr),
      .cnt     (cnt),
      .reload  (reload)
   );

   pwmb_bcast #(
      .NCH (NCH),
      .CW  (CW)
   ) u_bcast (
      .clk        (clk),
      .rst_n      (rst_n),
      .shared_we  (shared_we),
      .shared_val (wr_data[CW-1:0]),
      .mask_we    (mask_we),
      .mask       (wr_data[NCH-1:0]),
      .ready      (ready),
      .stage_we   (stage_we),
      .stage_val  (stage_val)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pwmb_channel #(
         .CW        (CW),
         .FALL_EDGE ((i % 2) == 1)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .stage_we  (stage_we[i]),
         .stage_val (stage_val),
         .reload    (reload),
         .cnt       (cnt),
         .pwm       (pwm_o[i])
      );
   end

   AST_BUSY_MASK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (mask_we && !ready) |-> (stage_we == '0)); // R7
   AST_CLEAR_RELOADS: assert property (@(posedge clk) disable iff (!rst_n) clr |-> reload); // R10

endmodule

// File: tb/pwm_bcast_bench.sv
module pwm_bcast_bench;

   localparam int PER = 10;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        ready;
   logic [3:0]  pwm_o;

   int cyc = 0;
   int checks = 0;
   int failures = 0;
   int hi [NCH];
   bit done = 1'b0;

   pwm_bcast u_pwm_bcast (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ready   (ready),
      .pwm_o   (pwm_o)
   );

   always #(PER/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_now(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_sample(input int n);
      do begin
         @(posedge clk);
         #(PER/4);
      end while (cyc < n);
   endtask

   task automatic measure(input int top, input int ca);
      for (int c = 0; c < NCH; c++) hi[c] = 0;
      for (int j = 3; j <= top + 3; j++) begin
         wait_sample(ca + j);
         for (int c = 0; c < NCH; c++) hi[c] += int'(pwm_o[c]);
      end
   endtask

   function automatic int exp_hi(input int d, input int top);
      if (d == 0) return 0;
      if (d == 1) return 2;
      if (d >= top) return top + 1;
      return d + 1;
   endfunction

   initial begin
      #(PER * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int ca;
      int cm;
      int tops [4] = '{1, 3, 7, 12};

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      wait_sample(cyc + 2);
      check("R11 outputs low after reset", int'(pwm_o), 0);
      check("R11 ready high after reset", int'(ready), 1);

      // R2 R3 R1 R10: sweep duty per channel over several top values
      for (int t = 0; t < 4; t++) begin
         for (int b = 0; b <= tops[t] + 2; b += 4) begin
            wr(2'd1, 32'(tops[t]));
            for (int c = 0; c < NCH; c++) begin
               wr(2'd2, 32'((b + c > 15) ? 15 : b + c));
               wr(2'd3, 32'(1) << c);
            end
            wr(2'd0, 32'd1);
            ca = cyc;
            measure(tops[t], ca);
            for (int c = 0; c < NCH; c++) begin
               int d;
               d = (b + c > 15) ? 15 : b + c;
               check($sformatf("%s R1 R10 ch%0d duty %0d top %0d",
                     (d == 0) ? "R2" : "R3", c, d, tops[t]),
                     hi[c], exp_hi(d, tops[t]));
            end
         end
      end

      // R4: edge split, all channels duty 1, top 9
      wr(2'd1, 32'd9);
      wr(2'd2, 32'd1);
      wr(2'd3, 32'hF);
      wr(2'd0, 32'd1);
      ca = cyc;
      wait_sample(ca + 2);
      check("R4 after rising edge all show count 1", int'(pwm_o), 4'hF);
      @(negedge clk);
      #(PER/4);
      check("R4 after falling edge odd show count 2", int'(pwm_o), 4'b0101);

      // R9: new top written mid-period waits for the wrap
      wr(2'd0, 32'd1);
      ca = cyc;
      wr(2'd1, 32'd3);
      for (int j = 4; j <= 16; j++) begin
         wait_sample(ca + j);
         check($sformatf("R9 ch0 sample %0d", j), int'(pwm_o[0]),
               (j <= 10) ? 0 : int'(((j - 11) % 4) < 2));
      end

      // R8: new duty written mid-period waits for the wrap
      wr(2'd1, 32'd9);
      wr(2'd2, 32'd3);
      wr(2'd3, 32'hF);
      wr(2'd0, 32'd1);
      ca = cyc;
      wr(2'd2, 32'd7);
      wr(2'd3, 32'hF);
      cm = cyc;
      for (int j = cm - ca + 2; j <= 19; j++) begin
         wait_sample(ca + j);
         check($sformatf("R8 sample %0d", j), int'(pwm_o),
               (j >= 11 && j <= 18) ? 15 : 0);
      end

      // R5 R6 R7: selective mask, busy window, ignored mask write
      wr(2'd2, 32'd0);
      wr(2'd3, 32'hF);
      wr(2'd2, 32'd2);
      wr(2'd3, 32'h4);
      wr(2'd2, 32'd5);
      wr(2'd3, 32'h1);
      check("R7 ready low one cycle after mask", int'(ready), 0);
      wr_now(2'd3, 32'h2);
      check("R7 ready back high", int'(ready), 1);
      wr(2'd0, 32'd1);
      ca = cyc;
      measure(9, ca);
      check("R6 R5 ch0 selected duty 5", hi[0], 6);
      check("R7 ch1 busy mask write ignored", hi[1], 0);
      check("R6 ch2 unselected keeps duty 2", hi[2], 3);
      check("R6 ch3 unselected keeps duty 0", hi[3], 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule